// File: doc/BRIEF.md
# Ping-Pong Conversion Group Controller

This block sits in front of a single analog-to-digital converter. It decides which of several channel-control groups may start a conversion. Each group holds a 5-bit channel number and an interrupt-enable bit, and software loads a group through a simple one-cycle write port. In software trigger mode, only group 0 starts conversions, and a write to group 0 starts one at once. In hardware trigger mode, a per-group trigger input starts conversions. The groups take turns in a fixed rotating order. At most one group controls the converter at any time.

The block sends a one-cycle start request and the channel of the active group to the converter. It then waits for the converter's done strobe. On that strobe it stores the converter's data in the active group's result register and sets that group's completion flag. If software writes the active group while the conversion runs, the conversion is aborted. A write to any other group leaves the running conversion alone. In software mode, continuous mode restarts group 0 after every completion.

The controller is a three-state machine:
- ST_IDLE: no conversion.
- ST_START: issues the start request for one cycle.
- ST_WAIT: waits for the done strobe.

Its transitions are:
- IDLE→START on an accepted software write or hardware trigger.
- START→WAIT when nothing else happens.
- WAIT→IDLE on completion or on an abort.
- WAIT→START on a completion in continuous mode.
- START/WAIT→START when group 0 is rewritten in software mode (abort and restart).
- START/WAIT→IDLE on any other abort.

Top module: `conv_group_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start`, `conv_abort` and `irq` are low, all completion flags are zero, and the hardware turn points to group 0.
- R2: In software mode (`hw_mode`=0), a write to group 0 while idle raises `conv_start` for the next cycle, with `conv_chan` equal to the written channel. `busy` stays high from that cycle until the conversion ends.
- R3: In software mode, a write to any group other than 0 never starts a conversion, and `busy` stays low.
- R4: In hardware mode, no write starts a conversion. While idle, a high `hw_trig[n]` starts a conversion of group n's stored channel, but only when n is the group whose turn it is.
- R5: In hardware mode, the turn is group 0 after reset. It advances by one, wrapping modulo NUM_GROUPS, after each completed conversion. A trigger for another group, or any trigger that arrives while busy, is ignored and is not remembered.
- R6: A `conv_done` strobe in ST_WAIT stores `conv_data` into the active group's result register, sets that group's completion flag, and ends the conversion at the same edge.
- R7: `irq` is high exactly when some group has both its completion flag and its interrupt enable set.
- R8: `rd_data` shows the result register of group `rd_grp`. A cycle with `rd_en` high clears that group's completion flag.
- R9: A write to the active group while busy raises `conv_abort` in that write cycle. The conversion then sets no flag and stores no result. It ends at the next edge, except that in software mode a write to group 0 restarts group 0 with the new channel.
- R10: A write to a group other than the active one while busy raises no abort, and the running conversion completes normally.
- R11: In software mode with `cont_mode` set, each completion is followed by a new group-0 start request in the very next cycle, and `busy` does not drop.
- R12: Every channel number from 0 to 31 is passed through unchanged to `conv_chan` and gives its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Group write strobe |
| wr_grp | input | GRP_W | Group being written |
| wr_chan | input | CH_W | Channel number to store |
| wr_ie | input | 1 | Interrupt enable to store |
| hw_mode | input | 1 | 1 = hardware trigger mode, 0 = software |
| cont_mode | input | 1 | Continuous conversion (software mode) |
| hw_trig | input | NUM_GROUPS | Per-group hardware trigger |
| rd_en | input | 1 | Result read strobe, clears the flag |
| rd_grp | input | GRP_W | Group whose result is read |
| rd_data | output | DATA_W | Result register of `rd_grp` |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | CH_W | Channel of the active group |
| conv_abort | output | 1 | Abort of the running conversion |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | DATA_W | Converter result |
| busy | output | 1 | Converter-active flag |
| act_grp | output | GRP_W | Group controlling the converter |
| done_flags | output | NUM_GROUPS | Per-group completion flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_GROUPS=3 instead of the default 2. With three groups, the hardware turn must visibly wrap from group 2 back to group 0, and a trigger for a group that is neither the current nor the previous one can be shown to be ignored. CH_W stays 5, so the software-mode sweep covers all 32 channel numbers. For each channel, the expected result comes from a formula in the converter stub. Abort, restart and continuous mode are then run on top of that state.

// File: rtl/conv_grp_pkg.sv
package conv_grp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } cg_state_e;
endpackage

// File: rtl/conv_grp_regs.sv
module conv_grp_regs #(
    parameter int NUM_GROUPS = 2,
    parameter int CH_W       = 5,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [GRP_W-1:0]                 wr_grp,
    input  logic [CH_W-1:0]                  wr_chan,
    input  logic                             wr_ie,
    output logic [NUM_GROUPS-1:0][CH_W-1:0]  chan_tbl,
    output logic [NUM_GROUPS-1:0]            ie_vec
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_tbl[g] <= '0;
                ie_vec[g]   <= 1'b0;
            end else if (wr_en && wr_grp == GRP_W'(g)) begin
                chan_tbl[g] <= wr_chan;
                ie_vec[g]   <= wr_ie;
            end
        end
    end
endmodule

// File: rtl/conv_grp_fsm.sv
module conv_grp_fsm
    import conv_grp_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GRP_W-1:0]      wr_grp,
    input  logic                  hw_mode,
    input  logic                  cont_mode,
    input  logic [NUM_GROUPS-1:0] hw_trig,
    input  logic                  conv_done,
    output logic                  conv_start,
    output logic                  conv_abort,
    output logic                  busy,
    output logic [GRP_W-1:0]      act_grp,
    output logic                  cmp_stb
);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    cg_state_e        state, state_nx;
    logic [GRP_W-1:0] grp_nx;
    logic [GRP_W-1:0] turn;
    logic             hit_active, sw_go, hw_go, done_ok;

    assign hit_active = wr_en && (state != ST_IDLE) && (wr_grp == act_grp);
    assign sw_go      = wr_en && !hw_mode && (wr_grp == '0);
    assign hw_go      = hw_mode && hw_trig[turn];
    assign done_ok    = (state == ST_WAIT) && conv_done && !hit_active;

    always_comb begin
        state_nx = state;
        grp_nx   = act_grp;
        unique case (state)
            ST_IDLE: begin
                if (sw_go) begin
                    state_nx = ST_START;
                    grp_nx   = '0;
                end else if (hw_go) begin
                    state_nx = ST_START;
                    grp_nx   = turn;
                end
            end
            ST_START, ST_WAIT: begin
                if (hit_active) begin
                    state_nx = sw_go ? ST_START : ST_IDLE;
                    grp_nx   = '0;
                end else if (done_ok) begin
                    if (cont_mode && !hw_mode) begin
                        state_nx = ST_START;
                        grp_nx   = '0;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (state == ST_START) begin
                    state_nx = ST_WAIT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            act_grp <= '0;
            turn    <= '0;
        end else begin
            state   <= state_nx;
            act_grp <= grp_nx;
            if (done_ok && hw_mode)
                turn <= (turn == LAST_GRP) ? '0 : turn + GRP_W'(1);
        end
    end

    always_comb begin
        conv_start = (state == ST_START);
        busy       = (state != ST_IDLE);
        conv_abort = hit_active;
        cmp_stb    = done_ok;
    end

    assert_sw_other_grp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hw_mode && wr_en && wr_grp != '0) |=> !busy);
    assert_hw_no_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hw_mode && hw_trig == '0) |=> !busy);
    assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_abort && (hw_mode || wr_grp != '0)) |=> !busy);
    assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && conv_done && !wr_en && !cont_mode) |=> !busy);
    assert_cont_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && cont_mode && !hw_mode) |=> conv_start);
    assert_grp_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !conv_abort && !conv_done) |=> (busy && $stable(act_grp)));
endmodule

// File: rtl/conv_grp_results.sv
module conv_grp_results #(
    parameter int NUM_GROUPS = 2,
    parameter int DATA_W     = 12,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_stb,
    input  logic [GRP_W-1:0]      cmp_grp,
    input  logic [DATA_W-1:0]     conv_data,
    input  logic                  rd_en,
    input  logic [GRP_W-1:0]      rd_grp,
    input  logic [NUM_GROUPS-1:0] ie_vec,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_GROUPS-1:0] flags,
    output logic                  irq
);
    logic [NUM_GROUPS-1:0][DATA_W-1:0] result;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result[g] <= '0;
                flags[g]  <= 1'b0;
            end else if (cmp_stb && cmp_grp == GRP_W'(g)) begin
                result[g] <= conv_data;
                flags[g]  <= 1'b1;
            end else if (rd_en && rd_grp == GRP_W'(g)) begin
                flags[g]  <= 1'b0;
            end
        end
    end

    assign rd_data = result[rd_grp];
    assign irq     = |(flags & ie_vec);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb |=> flags[$past(cmp_grp)]);
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cmp_stb) |=> !flags[$past(rd_grp)]);
endmodule

// File: rtl/conv_group_ctrl.sv
module conv_group_ctrl #(
    parameter int NUM_GROUPS = 2,
    parameter int CH_W       = 5,
    parameter int DATA_W     = 12,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GRP_W-1:0]      wr_grp,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic                  wr_ie,
    input  logic                  hw_mode,
    input  logic                  cont_mode,
    input  logic [NUM_GROUPS-1:0] hw_trig,
    input  logic                  rd_en,
    input  logic [GRP_W-1:0]      rd_grp,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  conv_start,
    output logic [CH_W-1:0]       conv_chan,
    output logic                  conv_abort,
    input  logic                  conv_done,
    input  logic [DATA_W-1:0]     conv_data,
    output logic                  busy,
    output logic [GRP_W-1:0]      act_grp,
    output logic [NUM_GROUPS-1:0] done_flags,
    output logic                  irq
);
    logic [NUM_GROUPS-1:0][CH_W-1:0] chan_tbl;
    logic [NUM_GROUPS-1:0]           ie_vec;
    logic                            cmp_stb;

    conv_grp_regs #(.NUM_GROUPS(NUM_GROUPS), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_chan(wr_chan), .wr_ie(wr_ie), .chan_tbl(chan_tbl), .ie_vec(ie_vec)
    );

    conv_grp_fsm #(.NUM_GROUPS(NUM_GROUPS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .hw_mode(hw_mode), .cont_mode(cont_mode), .hw_trig(hw_trig),
        .conv_done(conv_done), .conv_start(conv_start), .conv_abort(conv_abort),
        .busy(busy), .act_grp(act_grp), .cmp_stb(cmp_stb)
    );

    conv_grp_results #(.NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cmp_stb(cmp_stb), .cmp_grp(act_grp),
        .conv_data(conv_data), .rd_en(rd_en), .rd_grp(rd_grp), .ie_vec(ie_vec),
        .rd_data(rd_data), .flags(done_flags), .irq(irq)
    );

    assign conv_chan = chan_tbl[act_grp];

    assert_start_has_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
endmodule

// File: tb/conv_group_ctrl_tb.sv
module conv_group_ctrl_tb;
    localparam int NG = 3;
    localparam int GW = 2;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_ie = 0, hw_mode = 0, cont_mode = 0, rd_en = 0, conv_done;
    logic [GW-1:0] wr_grp = '0, rd_grp = '0, act_grp;
    logic [4:0] wr_chan = '0, conv_chan, stub_ch;
    logic [NG-1:0] hw_trig = '0, done_flags;
    logic [11:0] rd_data, conv_data;
    logic conv_start, conv_abort, busy, irq;
    int stub_cnt;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    conv_group_ctrl #(.NUM_GROUPS(NG), .CH_W(5), .DATA_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp), .wr_chan(wr_chan),
        .wr_ie(wr_ie), .hw_mode(hw_mode), .cont_mode(cont_mode), .hw_trig(hw_trig),
        .rd_en(rd_en), .rd_grp(rd_grp), .rd_data(rd_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_abort(conv_abort), .conv_done(conv_done),
        .conv_data(conv_data), .busy(busy), .act_grp(act_grp),
        .done_flags(done_flags), .irq(irq)
    );

    function automatic logic [11:0] expv(input int ch);
        return 12'((ch * 37 + 5) & 12'hFFF);
    endfunction

    // converter stub: done LAT edges after the start request
    always_ff @(posedge clk) begin
        if (!rst_n || conv_abort) stub_cnt <= 0;
        else if (conv_start) begin
            stub_cnt <= LAT;
            stub_ch  <= conv_chan;
        end else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
    end
    assign conv_done = (stub_cnt == 1);
    assign conv_data = expv(int'(stub_ch));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int g, input int ch, input bit ie);
        @(negedge clk);
        wr_en = 1; wr_grp = GW'(g); wr_chan = 5'(ch); wr_ie = ie;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_trig(input int n);
        @(negedge clk);
        hw_trig = '0; hw_trig[n] = 1'b1;
        @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    task automatic read_grp(input int g, output int val);
        @(negedge clk);
        rd_en = 1; rd_grp = GW'(g);
        #1 val = int'(rd_data);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 start", conv_start, 0);
        chk("R1 flags", int'(done_flags), 0);
        chk("R1 irq", irq, 0);

        // R2 / R12 / R6 / R7 / R8: sweep every channel in software mode
        for (int ch = 0; ch < 32; ch++) begin
            do_write(0, ch, ch[0]);
            chk("R2 start", conv_start, 1);
            chk("R12 chan", int'(conv_chan), ch);
            chk("R2 busy", busy, 1);
            wait_idle();
            chk("R6 flag", done_flags[0], 1);
            chk("R7 irq", irq, ch[0]);
            read_grp(0, v);
            chk("R12 result", v, int'(expv(ch)));
            chk("R8 cleared", done_flags[0], 0);
        end

        // R3: software mode, other groups never start
        do_write(1, 6, 0);
        chk("R3 grp1 no start", busy, 0);
        do_write(2, 8, 1);
        @(negedge clk);
        chk("R3 grp2 no start", busy, 0);

        // R4: hardware mode, write to group 0 does not start
        hw_mode = 1;
        do_write(0, 11, 1);
        @(negedge clk);
        chk("R4 write no start", busy, 0);

        // R9: abort by writing active group in hardware mode
        pulse_trig(0);
        chk("R4 trig0 start", conv_start, 1);
        chk("R4 trig0 chan", int'(conv_chan), 11);
        @(negedge clk);
        wr_en = 1; wr_grp = 0; wr_chan = 12; wr_ie = 1;
        #1 chk("R9 abort strobe", conv_abort, 1);
        @(negedge clk);
        wr_en = 0;
        chk("R9 busy dropped", busy, 0);
        repeat (5) @(negedge clk);
        chk("R9 no flag", int'(done_flags), 0);
        read_grp(0, v);
        chk("R9 result kept", v, int'(expv(31)));

        // R10: write other group while busy; turn still 0 after abort
        pulse_trig(0);
        chk("R5 turn kept after abort", conv_chan, 12);
        @(negedge clk);
        wr_en = 1; wr_grp = 1; wr_chan = 20; wr_ie = 0;
        #1 chk("R10 no abort", conv_abort, 0);
        @(negedge clk);
        wr_en = 0;
        wait_idle();
        chk("R10 flag", done_flags[0], 1);
        chk("R7 irq ie0", irq, 1);
        read_grp(0, v);
        chk("R10 result", v, int'(expv(12)));

        // R5: ping-pong turn now group 1
        pulse_trig(0);
        chk("R5 trig0 out of turn", busy, 0);
        pulse_trig(2);
        chk("R5 trig2 out of turn", busy, 0);
        pulse_trig(1);
        chk("R5 trig1 start", conv_start, 1);
        chk("R5 trig1 chan", int'(conv_chan), 20);
        hw_trig = 3'b100;
        @(negedge clk);
        hw_trig = '0;
        wait_idle();
        chk("R6 grp1 flag", done_flags[1], 1);
        chk("R7 irq ie off", irq, 0);
        @(negedge clk);
        chk("R5 busy trig not kept", busy, 0);
        read_grp(1, v);
        chk("R6 grp1 result", v, int'(expv(20)));
        do_write(2, 7, 0);
        chk("R4 grp2 write no start", busy, 0);
        pulse_trig(2);
        chk("R5 trig2 chan", int'(conv_chan), 7);
        wait_idle();
        read_grp(2, v);
        chk("R5 grp2 result", v, int'(expv(7)));
        pulse_trig(0);
        chk("R5 wrap to grp0", conv_start, 1);
        wait_idle();
        read_grp(0, v);

        // R9: software restart of group 0
        hw_mode = 0;
        do_write(0, 3, 0);
        do_write(0, 9, 0);
        chk("R9 restart start", conv_start, 1);
        chk("R9 restart chan", int'(conv_chan), 9);
        wait_idle();
        read_grp(0, v);
        chk("R9 restart result", v, int'(expv(9)));

        // R11: continuous mode
        cont_mode = 1;
        do_write(0, 4, 0);
        for (int i = 0; i < 40 && !done_flags[0]; i++) @(negedge clk);
        chk("R11 restart start", conv_start, 1);
        chk("R11 busy held", busy, 1);
        cont_mode = 0;
        wait_idle();
        chk("R11 ended", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule